// File: doc/BRIEF.md
# Return Address Stack

This block keeps the return addresses that a processor core saves when it enters a subroutine or takes an interrupt, and gives them back when the matching return executes. Each entry is as wide as the program counter. The stack storage lives apart from program and data memory. Pointer value zero is the empty position and has no storage behind it. A push first advances the pointer and then stores the program counter at the new level. A pop first hands out the entry at the current level and then steps the pointer back.

Software can read and write the pointer and the top entry through register-style ports. A level output reports when the stack has reached its last level. Two sticky flags record a push made against a full stack and a pop made against an empty one. Push and pop are single-cycle strobes from the core and are always accepted, so the block never applies back-pressure. Misuse shows up in the status flags. Every command input is sampled on the rising clock edge. Every result appears on the outputs one cycle later.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset the pointer is 0, both sticky flags are 0, and the top-of-stack and popped-address outputs are 0.
- R2: A push with the pointer below 31 increments the pointer and stores the pushed program counter at the new level. On the next cycle the pointer and the top-of-stack output show the new values.
- R3: A pop with the pointer above 0 places the entry at the current level on the popped-address output in the next cycle and decrements the pointer. Over the full 31 levels, values come back in reverse order of pushing.
- R4: The full output is high exactly when the pointer equals 31.
- R5: A push with the pointer at 31 sets the overflow flag and changes neither the pointer nor any stored entry.
- R6: A pop with the pointer at 0 sets the underflow flag, drives the popped-address output to 0 and leaves the pointer at 0.
- R7: A pointer write loads the pointer and clears both flags. Pointer writes above 31 load 31. In that cycle any push, pop or top-entry write is ignored.
- R8: A top-entry write without a pointer write replaces the entry at the current level when the pointer is non-zero. At pointer 0 it changes nothing, and the top-of-stack output reads 0. A top-entry write overrides push and pop in the same cycle.
- R9: When push and pop are asserted together with no register write, only the push takes effect.
- R10: Once set, each sticky flag stays set until reset or a pointer write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Save a return address (call or interrupt acknowledge) |
| pop_i | input | 1 | Retrieve a return address (return-type operation) |
| push_pc_i | input | 21 | Program counter value to save |
| ptr_we_i | input | 1 | Pointer register write strobe |
| ptr_wdata_i | input | 5 | New pointer value |
| tos_we_i | input | 1 | Top-entry register write strobe |
| tos_wdata_i | input | 21 | New top-entry value |
| pop_addr_o | output | 21 | Address produced by the last pop |
| ptr_o | output | 5 | Current pointer |
| tos_o | output | 21 | Entry at the current level, 0 at level 0 |
| full_o | output | 1 | Pointer is at the last level |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |

## Verification
The assertions check the pointer step for each command on every cycle. They also check the pointer bound, the full output, and the setting, holding and clearing of both flags. They check the popped value against the previous top entry, and the visibility of a pushed value. Only the bench scenarios can show that contents survive over the whole depth: the full LIFO order, an overflowing push that leaves entry 31 intact, a top-entry write at level 0 that leaves entry 1 untouched, and a pointer sweep that reads back every stored level.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [2:0] {
    RS_IDLE,
    RS_SETPTR,
    RS_SETTOS,
    RS_PUSH,
    RS_POP
  } rs_op_e;

  // register writes outrank stack traffic; push outranks pop
  function automatic rs_op_e rs_pick(input logic ptr_we, input logic tos_we,
                                     input logic push, input logic pop);
    if (ptr_we)      return RS_SETPTR;
    else if (tos_we) return RS_SETTOS;
    else if (push)   return RS_PUSH;
    else if (pop)    return RS_POP;
    else             return RS_IDLE;
  endfunction
endpackage

// File: rtl/rs_ptr_ctrl.sv
module rs_ptr_ctrl
  import rs_pkg::*;
#(
  parameter int DEPTH = 31,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rs_op_e        op,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] ptr_q,
  output logic          ovf_q,
  output logic          unf_q,
  output logic          full,
  output logic          empty,
  output logic          wr_en,
  output logic [PW-1:0] wr_idx
);
  localparam logic [PW-1:0] TOP = PW'(DEPTH);

  logic [PW-1:0] ptr_inc;
  logic [PW-1:0] ptr_dec;
  logic [PW-1:0] wdata_cl;

  assign full     = (ptr_q == TOP);
  assign empty    = (ptr_q == '0);
  assign ptr_inc  = ptr_q + 1'b1;
  assign ptr_dec  = ptr_q - 1'b1;
  assign wdata_cl = (wdata > TOP) ? TOP : wdata;

  always_comb begin
    wr_en  = 1'b0;
    wr_idx = ptr_q;
    unique case (op)
      RS_PUSH: begin
        wr_en  = !full;
        wr_idx = ptr_inc;
      end
      RS_SETTOS: wr_en = !empty;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      unique case (op)
        RS_SETPTR: begin
          ptr_q <= wdata_cl;
          ovf_q <= 1'b0;
          unf_q <= 1'b0;
        end
        RS_PUSH: begin
          if (full) ovf_q <= 1'b1;
          else      ptr_q <= ptr_inc;
        end
        RS_POP: begin
          if (empty) unf_q <= 1'b1;
          else       ptr_q <= ptr_dec;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rs_store.sv
module rs_store #(
  parameter int DEPTH = 31,
  parameter int AW    = 21,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic [PW-1:0] rd_idx,
  output logic [AW-1:0] rd_data
);
  // level 0 is the empty position and owns no storage
  logic [AW-1:0] ent [1:DEPTH];
  logic [DEPTH:1] hit_w;
  logic [DEPTH:1] hit_r;

  for (genvar e = 1; e <= DEPTH; e++) begin : g_dec
    assign hit_w[e] = wr_en && (wr_idx == PW'(e));
    assign hit_r[e] = (rd_idx == PW'(e));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 1; e <= DEPTH; e++) ent[e] <= '0;
    end else begin
      for (int e = 1; e <= DEPTH; e++)
        if (hit_w[e]) ent[e] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int e = 1; e <= DEPTH; e++)
      if (hit_r[e]) rd_data = ent[e];
  end
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import rs_pkg::*;
#(
  parameter int DEPTH = 31,
  parameter int AW    = 21,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] push_pc_i,
  input  logic          ptr_we_i,
  input  logic [PW-1:0] ptr_wdata_i,
  input  logic          tos_we_i,
  input  logic [AW-1:0] tos_wdata_i,
  output logic [AW-1:0] pop_addr_o,
  output logic [PW-1:0] ptr_o,
  output logic [AW-1:0] tos_o,
  output logic          full_o,
  output logic          ovf_o,
  output logic          unf_o
);
  rs_op_e        op;
  logic          empty;
  logic          wr_en;
  logic [PW-1:0] wr_idx;
  logic [AW-1:0] wr_data;
  logic [AW-1:0] rd_data;

  assign op      = rs_pick(ptr_we_i, tos_we_i, push_i, pop_i);
  assign wr_data = (op == RS_PUSH) ? push_pc_i : tos_wdata_i;

  rs_ptr_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .wdata  (ptr_wdata_i),
    .ptr_q  (ptr_o),
    .ovf_q  (ovf_o),
    .unf_q  (unf_o),
    .full   (full_o),
    .empty  (empty),
    .wr_en  (wr_en),
    .wr_idx (wr_idx)
  );

  rs_store #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (ptr_o),
    .rd_data (rd_data)
  );

  assign tos_o = rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n)            pop_addr_o <= '0;
    else if (op == RS_POP) pop_addr_o <= empty ? '0 : rd_data;
  end
endmodule

// File: rtl/ret_addr_stack_chk.sv
module ret_addr_stack_chk #(
  parameter int DEPTH = 31,
  parameter int AW    = 21,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_i,
  input logic          pop_i,
  input logic [AW-1:0] push_pc_i,
  input logic          ptr_we_i,
  input logic [PW-1:0] ptr_wdata_i,
  input logic          tos_we_i,
  input logic [AW-1:0] pop_addr_o,
  input logic [PW-1:0] ptr_o,
  input logic [AW-1:0] tos_o,
  input logic          full_o,
  input logic          ovf_o,
  input logic          unf_o
);
  localparam logic [PW-1:0] TOP = PW'(DEPTH);
  logic stk_cmd;
  assign stk_cmd = !ptr_we_i && !tos_we_i;

  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_cmd && push_i && ptr_o != TOP) |=> (ptr_o == $past(ptr_o) + 1'b1 && tos_o == $past(push_pc_i)));
  // R3
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_cmd && pop_i && !push_i && ptr_o != '0) |=> (ptr_o == $past(ptr_o) - 1'b1 && pop_addr_o == $past(tos_o)));
  // R4
  full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_o == (ptr_o == TOP) && ptr_o <= TOP);
  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_cmd && push_i && ptr_o == TOP) |=> (ovf_o && $stable(ptr_o) && $stable(tos_o)));
  // R6
  unf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_cmd && pop_i && !push_i && ptr_o == '0) |=> (unf_o && ptr_o == '0 && pop_addr_o == '0));
  // R7
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we_i && ptr_wdata_i <= TOP) |=> (ptr_o == $past(ptr_wdata_i) && !ovf_o && !unf_o));
  // R8
  tos_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_o == '0) |-> (tos_o == '0));
  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_we_i && (ovf_o || unf_o)) |=> (ovf_o >= $past(ovf_o) && unf_o >= $past(unf_o)));
endmodule

bind ret_addr_stack ret_addr_stack_chk #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .push_pc_i(push_pc_i),
  .ptr_we_i(ptr_we_i), .ptr_wdata_i(ptr_wdata_i), .tos_we_i(tos_we_i),
  .pop_addr_o(pop_addr_o), .ptr_o(ptr_o), .tos_o(tos_o), .full_o(full_o),
  .ovf_o(ovf_o), .unf_o(unf_o)
);

// File: tb/ret_addr_stack_tb.sv
module ret_addr_stack_tb;
  localparam int DEPTH = 31;
  localparam int AW    = 21;
  localparam int PW    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_i = 0, pop_i = 0, ptr_we_i = 0, tos_we_i = 0;
  logic [AW-1:0] push_pc_i = '0, tos_wdata_i = '0;
  logic [PW-1:0] ptr_wdata_i = '0;
  logic [AW-1:0] pop_addr_o, tos_o;
  logic [PW-1:0] ptr_o;
  logic full_o, ovf_o, unf_o;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ret_addr_stack #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_dut (.*);

  function automatic logic [AW-1:0] pc_of(input int i);
    return AW'(i * 32'h1357 + 32'h0ABC);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // inputs set after a falling edge, outputs sampled at the next falling edge
  task automatic cyc(input logic ps, input logic pp, input logic [AW-1:0] pc,
                     input logic pwe, input logic [PW-1:0] pwd,
                     input logic twe, input logic [AW-1:0] twd);
    push_i = ps; pop_i = pp; push_pc_i = pc;
    ptr_we_i = pwe; ptr_wdata_i = pwd; tos_we_i = twe; tos_wdata_i = twd;
    @(negedge clk);
    push_i = 0; pop_i = 0; ptr_we_i = 0; tos_we_i = 0;
  endtask

  task automatic setp(input int k);
    cyc(0, 0, '0, 1, PW'(k), 0, '0);
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 ptr", ptr_o, 0); chk("R1 ovf", ovf_o, 0); chk("R1 unf", unf_o, 0);
    chk("R1 tos", tos_o, 0); chk("R1 pop", pop_addr_o, 0);
    // R6
    cyc(0, 1, '0, 0, '0, 0, '0);
    chk("R6 unf", unf_o, 1); chk("R6 ptr", ptr_o, 0); chk("R6 pop", pop_addr_o, 0);
    // R10
    cyc(0, 0, '0, 0, '0, 0, '0);
    chk("R10 unf held", unf_o, 1);
    // R7
    setp(0);
    chk("R7 unf cleared", unf_o, 0);
    // R2, R4
    for (int i = 1; i <= DEPTH; i++) begin
      cyc(1, 0, pc_of(i), 0, '0, 0, '0);
      chk("R2 ptr", ptr_o, i); chk("R2 tos", tos_o, pc_of(i));
      chk("R4 full", full_o, i == DEPTH);
    end
    // R5
    cyc(1, 0, 21'h1FFFFF, 0, '0, 0, '0);
    chk("R5 ovf", ovf_o, 1); chk("R5 ptr", ptr_o, DEPTH); chk("R5 tos", tos_o, pc_of(DEPTH));
    cyc(0, 0, '0, 0, '0, 0, '0);
    chk("R10 ovf held", ovf_o, 1);
    // R7 sweep: every level reads back, flags cleared
    for (int k = 0; k <= DEPTH; k++) begin
      setp(k);
      chk("R7 ptr", ptr_o, k); chk("R7 ovf", ovf_o, 0);
      chk("R8 tos level", tos_o, (k == 0) ? 0 : pc_of(k));
    end
    // R3 full LIFO
    for (int j = 0; j < DEPTH; j++) begin
      cyc(0, 1, '0, 0, '0, 0, '0);
      chk("R3 pop", pop_addr_o, pc_of(DEPTH - j));
      chk("R3 ptr", ptr_o, DEPTH - 1 - j);
    end
    // R8 write at level 0 is ignored
    cyc(0, 0, '0, 0, '0, 1, 21'h0F0F0);
    chk("R8 tos at 0", tos_o, 0);
    setp(1);
    chk("R8 entry1 kept", tos_o, pc_of(1));
    // R8 write at level 5, beats a push
    setp(5);
    cyc(1, 0, 21'h11111, 0, '0, 1, 21'h0ABCD);
    chk("R8 tos", tos_o, 21'h0ABCD); chk("R8 ptr", ptr_o, 5);
    cyc(0, 1, '0, 0, '0, 0, '0);
    chk("R8 pop", pop_addr_o, 21'h0ABCD); chk("R3 ptr", ptr_o, 4);
    // R9
    cyc(1, 1, 21'h13579, 0, '0, 0, '0);
    chk("R9 ptr", ptr_o, 5); chk("R9 tos", tos_o, 21'h13579);
    chk("R9 pop unchanged", pop_addr_o, 21'h0ABCD);
    // R7 pointer write beats a push
    cyc(1, 0, 21'h02468, 1, 5'd2, 0, '0);
    chk("R7 ptr over push", ptr_o, 2); chk("R7 tos", tos_o, pc_of(2));
    setp(3);
    chk("R7 entry3 kept", tos_o, pc_of(3));
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule